// File: doc/BRIEF.md
# Chained Prescaler Timer Unit

This block builds a long-interval periodic timer out of two equality-compared counters placed in series. The first counter works as a prescaler. It advances on every cycle of the chosen count source, which is either the block clock or a rising edge on an external pin. Each time it completes its programmed period, it emits one tick. The second counter, the main timer, advances once per tick. When it matches its own period, the block raises an interrupt strobe and a DMA event strobe, and it updates an output pin.

The output pin runs in one of two forms. In pulse form it is active for a programmable number of ticks, from one to four. In clock form it toggles on every match. Its polarity can be inverted. A small register file holds both periods, both counts and a control word. The control word starts, stops and reconfigures the main timer, but it does not gate the prescaler. Its reset bit clears both counters.

Top module: `chained_tick_timer`

## Requirements
- R1: The prescaler counts 0,1,...,P on successive count-source cycles, where P is the value at address 1. The cycle after it sits at P on a source cycle, it returns to 0 and issues one tick. One tick therefore occurs every P+1 source cycles.
- R2: While the run field (control bits [1:0]) is 2'b10 or 2'b11 (continuous), the main counter advances once per tick, not once per source cycle. After the tick on which it equals the main period M (address 2), it returns to 0. With the internal source, match strobes are therefore (P+1)*(M+1) clocks apart.
- R3: The interrupt strobe `irq` and the DMA strobe `dma_evt` assert together. Each lasts one clock and follows a tick on which the main count equals M.
- R4: In pulse form (control bit 2 = 0), the raw output becomes 1 at the match strobe and stays 1 for W ticks, where W = control bits [4:3] + 1. With the internal source this is W*(P+1) clocks.
- R5: In clock form (control bit 2 = 1), the raw output toggles at every match strobe.
- R6: `timer_out` equals the raw output XOR the invert bit (control bit 5). Read-only control bit 8 returns the raw output.
- R7: With run field 2'b00, the main counter holds its value, while the prescaler count keeps moving.
- R8: With run field 2'b01 (one-shot), the first match strobe also clears the run field to 2'b00. No further strobes follow.
- R9: Writing 1 to control bit 7 clears both counts to 0 in the same write cycle, so they read 0 afterwards. Bit 7 always reads 0.
- R10: With control bit 6 = 1, the prescaler counts rising edges of `ext_in` after a two-flop synchronizer, one count per edge. With the pin quiet, the count holds.
- R11: A write to address 3 or address 4 loads the prescaler count or the main count, and the loaded value reads back.
- R12: After reset, all registers read 0, and `irq`, `dma_evt` and `timer_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and internal count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_in | input | 1 | External count input (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 prescale period, 2 main period, 3 prescale count, 4 main count |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address, same map as writes |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | One-clock interrupt strobe on match |
| dma_evt | output | 1 | One-clock DMA event strobe on match |
| timer_out | output | 1 | Output pin, pulse or clock form, optional inversion |

## Verification
The bench measures the spacing of match strobes for several pairs of prescale and main periods, including a prescale period of zero. A design that restarted one counter a cycle early or late would give a spacing other than (P+1)*(M+1). It counts the active cycles of the output pulse for every width code, which would expose a width off by one tick. It checks that one-shot mode clears its own run field, and that a stopped timer still lets the prescaler run; a design that coupled the control word to the prescaler would freeze both counts. It counts edges on the external pin to catch a synchronizer that double-counts a held-high level.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRE_PRD = 3'd1;
  localparam logic [ADDR_W-1:0] A_MAIN_PRD = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRE_CNT = 3'd3;
  localparam logic [ADDR_W-1:0] A_MAIN_CNT = 3'd4;

  localparam int CB_RUN_LO = 0;
  localparam int CB_CLKM   = 2;
  localparam int CB_PW_LO  = 3;
  localparam int CB_INV    = 5;
  localparam int CB_EXT    = 6;
  localparam int CB_CLR    = 7;
  localparam int CB_STAT   = 8;
  localparam int CTRL_BITS = 9;

  typedef enum logic [1:0] {
    RUN_OFF  = 2'b00,
    RUN_ONCE = 2'b01,
    RUN_CONT = 2'b10,
    RUN_CONT2 = 2'b11
  } run_mode_e;

  // Next value of an equality-compared counter: back to zero on match.
  function automatic logic [31:0] next_count(input logic [31:0] cnt,
                                             input logic [31:0] prd);
    return (cnt == prd) ? 32'd0 : cnt + 32'd1;
  endfunction

  // Number of ticks a pulse lasts for a 2-bit width code.
  function automatic logic [2:0] pulse_ticks(input logic [1:0] code);
    return {1'b0, code} + 3'd1;
  endfunction
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic use_ext,
  output logic src_tick
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic             ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN-2:0], ext_in};
  end

  assign ext_rise = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
  assign src_tick = use_ext ? ext_rise : 1'b1;

  // R10: an external edge never yields two consecutive count enables
  assert_edge_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);
  import tmr_pkg::*;

  logic at_prd;
  assign at_prd = (cnt == prd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (ld) begin
      cnt  <= ld_val;
      tick <= 1'b0;
    end else begin
      tick <= src_tick & at_prd;
      if (src_tick) cnt <= CNT_W'(next_count(32'(cnt), 32'(prd)));
    end
  end

  // R1: a source cycle at the period yields a tick and a zero count next
  assert_tick_after_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && src_tick && at_prd) |=> (tick && cnt == '0));
  // R10: without a count enable the prescaler holds
  assert_hold_no_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && !src_tick) |=> ($stable(cnt) && !tick));
endmodule

// File: rtl/tmr_main_counter.sv
module tmr_main_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] prd,
  output logic [CNT_W-1:0] cnt,
  output logic             match_evt
);
  import tmr_pkg::*;

  assign match_evt = run & tick & (cnt == prd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (ld)          cnt <= ld_val;
    else if (run && tick) cnt <= CNT_W'(next_count(32'(cnt), 32'(prd)));
  end

  // R7: a stopped timer keeps its count
  assert_hold_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr && !ld) |=> $stable(cnt));
  // R2: a match returns the count to zero
  assert_wrap_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !clr && !ld) |=> (cnt == '0));
  // R2: no advance between ticks
  assert_no_step_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr && !ld) |=> $stable(cnt));
endmodule

// File: rtl/tmr_out_gen.sv
module tmr_out_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       match_evt,
  input  logic       clr,
  input  logic       clk_mode,
  input  logic [1:0] pw_code,
  input  logic       invert,
  output logic       out_raw,
  output logic       timer_out
);
  import tmr_pkg::*;

  logic [2:0] pulse_left;
  logic       tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_left <= '0;
      tgl_q      <= 1'b0;
    end else if (clr) begin
      pulse_left <= '0;
      tgl_q      <= 1'b0;
    end else begin
      if (match_evt)                      pulse_left <= pulse_ticks(pw_code);
      else if (tick && pulse_left != '0)  pulse_left <= pulse_left - 3'd1;
      if (match_evt) tgl_q <= ~tgl_q;
    end
  end

  assign out_raw   = clk_mode ? tgl_q : (pulse_left != '0);
  assign timer_out = out_raw ^ invert;

  // R4: the pulse down-counter never exceeds the widest code
  assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_left <= 3'd4);
  // R5: the clock-form level moves only on a match
  assert_toggle_only_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_evt && !clr) |=> $stable(tgl_q));
endmodule

// File: rtl/chained_tick_timer.sv
module chained_tick_timer #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_in,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq,
  output logic             dma_evt,
  output logic             timer_out
);
  import tmr_pkg::*;

  run_mode_e        run_q;
  logic             clkm_q, inv_q, ext_q;
  logic [1:0]       pw_q;
  logic [CNT_W-1:0] pre_prd_q, main_prd_q;

  logic             ctrl_wr, cnt_clr;
  logic             src_tick, pre_tick, match_evt, out_raw, running;
  logic [CNT_W-1:0] pre_cnt, main_cnt;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign cnt_clr = ctrl_wr && wr_data[CB_CLR];
  assign running = (run_q != RUN_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= RUN_OFF;
      clkm_q     <= 1'b0;
      pw_q       <= '0;
      inv_q      <= 1'b0;
      ext_q      <= 1'b0;
      pre_prd_q  <= '0;
      main_prd_q <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q  <= run_mode_e'(wr_data[CB_RUN_LO +: 2]);
        clkm_q <= wr_data[CB_CLKM];
        pw_q   <= wr_data[CB_PW_LO +: 2];
        inv_q  <= wr_data[CB_INV];
        ext_q  <= wr_data[CB_EXT];
      end else if (match_evt && run_q == RUN_ONCE) begin
        run_q <= RUN_OFF;
      end
      if (wr_en && wr_addr == A_PRE_PRD)  pre_prd_q  <= wr_data;
      if (wr_en && wr_addr == A_MAIN_PRD) main_prd_q <= wr_data;
    end
  end

  tmr_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .use_ext(ext_q),
    .src_tick(src_tick));

  tmr_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .clr(cnt_clr),
    .ld(wr_en && wr_addr == A_PRE_CNT), .ld_val(wr_data),
    .prd(pre_prd_q), .cnt(pre_cnt), .tick(pre_tick));

  tmr_main_counter #(.CNT_W(CNT_W)) u_main (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick), .run(running),
    .clr(cnt_clr), .ld(wr_en && wr_addr == A_MAIN_CNT), .ld_val(wr_data),
    .prd(main_prd_q), .cnt(main_cnt), .match_evt(match_evt));

  tmr_out_gen u_out (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick), .match_evt(match_evt),
    .clr(cnt_clr), .clk_mode(clkm_q), .pw_code(pw_q), .invert(inv_q),
    .out_raw(out_raw), .timer_out(timer_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      dma_evt <= 1'b0;
    end else begin
      irq     <= match_evt;
      dma_evt <= match_evt;
    end
  end

  logic [CTRL_BITS-1:0] ctrl_view;
  assign ctrl_view = {out_raw, 1'b0, ext_q, inv_q, pw_q, clkm_q, run_q};

  always_comb begin
    unique case (rd_addr)
      A_CTRL:     rd_data = CNT_W'(ctrl_view);
      A_PRE_PRD:  rd_data = pre_prd_q;
      A_MAIN_PRD: rd_data = main_prd_q;
      A_PRE_CNT:  rd_data = pre_cnt;
      A_MAIN_CNT: rd_data = main_cnt;
      default:    rd_data = '0;
    endcase
  end

  // R3: a strobe always follows a prescaler tick
  assert_strobe_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(pre_tick));
  // R3: both strobes move together
  assert_strobes_paired_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq == dma_evt);
  // R8: a one-shot match turns the timer off
  assert_oneshot_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && run_q == RUN_ONCE && !ctrl_wr) |=> (run_q == RUN_OFF));
endmodule

// File: tb/chained_tick_timer_test.sv
module chained_tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, dma_evt, timer_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  chained_tick_timer uut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .dma_evt(dma_evt), .timer_out(timer_out));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // Vector: {prescale period, main period, width code}
  localparam logic [23:0] VEC [5] = '{
    {8'd0, 8'd3, 8'd0},
    {8'd1, 8'd4, 8'd3},
    {8'd2, 8'd3, 8'd2},
    {8'd4, 8'd5, 8'd1},
    {8'd0, 8'd7, 8'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_irq(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1'b1; break; end
    end
  endtask

  logic [31:0] v, v2;
  bit ok;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    rd(3'd0, v); chk("R12 ctrl", v, 0);
    rd(3'd3, v); chk("R12 pre count", v, 0);
    rd(3'd4, v); chk("R12 main count", v, 0);
    chk("R12 outputs", {irq, dma_evt, timer_out}, 0);

    // R2 R3 R4: table of period pairs and widths, continuous mode (ctrl = 2 | pw<<3)
    for (int k = 0; k < 5; k++) begin
      int p, m, w, c, oc;
      p = int'(VEC[k][23:16]); m = int'(VEC[k][15:8]); w = int'(VEC[k][7:0]) + 1;
      wr(3'd0, 32'h0);
      wr(3'd1, 32'(p));
      wr(3'd2, 32'(m));
      wr(3'd0, 32'h80);
      wr(3'd0, 32'h2 | (32'(w - 1) << 3));
      wait_irq(ok);
      chk("R3 first strobe seen", 32'(ok), 1);
      chk("R3 dma with irq", 32'(dma_evt), 1);
      oc = timer_out ? 1 : 0;
      c = 0;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        c++;
        if (irq) break;
        if (timer_out) oc++;
      end
      chk("R2 strobe spacing", 32'(c), 32'((p + 1) * (m + 1)));
      chk("R4 pulse clocks", 32'(oc), 32'(w * (p + 1)));
    end

    // R9: reset bit clears both counts and reads 0
    wr(3'd0, 32'h82);
    rd(3'd3, v); chk("R9 pre count cleared", v, 0);
    rd(3'd4, v); chk("R9 main count cleared", v, 0);
    rd(3'd0, v); chk("R9 reset bit reads 0", {31'd0, v[7]}, 0);

    // R7: stopped main timer holds, prescaler keeps moving (P=7)
    wr(3'd0, 32'h0);
    wr(3'd1, 32'd7);
    wr(3'd4, 32'd2);
    rd(3'd4, v); rd(3'd3, v2);
    repeat (20) @(negedge clk);
    rd(3'd4, v); chk("R7 main count holds", v, 2);
    rd(3'd3, v);
    chk("R7 prescaler still counts", 32'(v != v2), 1);

    // R11: count loads read back
    wr(3'd4, 32'd5);
    rd(3'd4, v); chk("R11 main load", v, 5);
    wr(3'd1, 32'd100);
    wr(3'd3, 32'd3);
    rd(3'd3, v); chk("R11 prescale load", v, 3);

    // R8: one-shot clears run field and stops strobes
    wr(3'd1, 32'd1);
    wr(3'd2, 32'd2);
    wr(3'd0, 32'h80);
    wr(3'd0, 32'h1);
    wait_irq(ok);
    chk("R8 one-shot strobe", 32'(ok), 1);
    rd(3'd0, v); chk("R8 run field cleared", {30'd0, v[1:0]}, 0);
    begin
      int extra = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (irq) extra++;
      end
      chk("R8 no further strobes", 32'(extra), 0);
    end

    // R5 R6: clock form toggles on each match; status reports raw level
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd3);
    wr(3'd0, 32'h80);
    wr(3'd0, 32'h6);
    wait_irq(ok);
    v2 = {31'd0, timer_out};
    rd(3'd0, v); chk("R6 status equals raw", {31'd0, v[8]}, v2);
    wait_irq(ok);
    chk("R5 toggles per match", {31'd0, timer_out}, {31'd0, ~v2[0]});

    // R6: inversion with an idle pulse output
    wr(3'd0, 32'h80);
    wr(3'd0, 32'h20);
    @(negedge clk);
    chk("R6 inverted idle level", {31'd0, timer_out}, 1);
    rd(3'd0, v); chk("R6 status raw idle", {31'd0, v[8]}, 0);

    // R10: external source counts synchronized rising edges
    wr(3'd1, 32'd1000);
    wr(3'd0, 32'h40);
    wr(3'd0, 32'hC0);
    repeat (10) @(negedge clk);
    rd(3'd3, v); chk("R10 quiet pin holds", v, 0);
    for (int i = 0; i < 5; i++) begin
      ext_in = 1'b1; repeat (4) @(negedge clk);
      ext_in = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd(3'd3, v); chk("R10 edge count", v, 5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule